// File: doc/BRIEF.md
# Thirty-Two Line Pin Bank with Grouped Interrupts

This block gives software control of 32 general-purpose lines through a small word-wide register bus. Each line can be an input or an output. Each line has its own settings: direction, output level, blink enable, input inversion, and separate masks for level and edge interrupts. An output line either holds its programmed level or, when blink is enabled, follows a shared square wave produced by a free-running divider.

Input pads pass through a two-flop synchronizer. The synchronized level is then XORed with the line's inversion bit to give the data-in value. Level interrupts and edge detection both work on this data-in value. A rising data-in value latches a sticky bit in the edge cause register, and software clears that bit by writing zero to it. Each line's masked level cause and masked edge cause are ORed together. The lines are then summarized in groups of eight, which gives four interrupt outputs for a higher-level interrupt controller.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the direction register reads all ones and every other register reads zero. No line drives its pad (`pad_oe` is zero) and all four interrupt outputs are low.
- R2: A direction bit of 0 makes the line an output: `pad_oe` goes high and `pad_out` follows the output-level register. A direction bit of 1 makes it an input with `pad_oe` low.
- R3: The data-in value equals the pad level XORed with the inversion bit. It is readable two clock edges after the pad changes, and in the cycle after an inversion write.
- R4: A 0-to-1 change of a line's data-in value sets its edge cause bit one clock edge later. The bit stays set when the input falls again.
- R5: A write to the edge cause register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a new rising edge and a clearing write to the same bit meet on one clock edge, the bit ends up set.
- R7: A line's cause is (data-in AND level mask) OR (edge cause AND edge mask). Each cause is gated only by its own mask.
- R8: Interrupt output g is the OR of the causes of lines 8g to 8g+7.
- R9: An output line with its blink bit set toggles every BLINK_HALF cycles instead of holding its level. All blinking lines share one phase, and non-blinking lines are not affected.
- R10: Writing the inversion bit is itself a data-in change, so a write that turns a line's data-in from 0 to 1 sets its edge cause bit.
- R11: Register word addresses are: 0 direction, 1 output level, 2 blink, 3 inversion, 4 data-in (read-only), 5 edge cause, 6 edge mask, 7 level mask. Any other address reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq_grp | output | 4 | Per-group interrupt summaries |

## Verification
A wrong synchronizer depth or a missing inversion term shows up in the data-in readback, which is off by one edge or has the wrong bits within three cycles of a pad change. A cause register that loses a bit, or that fails to honour the zero-to-clear rule, shows at the next readback and, through the edge mask, on the group outputs in the same cycle. A swapped group index or a mask that gates the wrong cause moves or silences an interrupt output as soon as the mask is written. A wrong divider length changes the toggle count over a window of four half-periods.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR    = 4'd0,
    REG_OUT    = 4'd1,
    REG_BLINK  = 4'd2,
    REG_POL    = 4'd3,
    REG_DIN    = 4'd4,
    REG_ECAUSE = 4'd5,
    REG_EMASK  = 4'd6,
    REG_LMASK  = 4'd7
  } reg_sel_e;

endpackage

// File: rtl/gpio_in_stage.sv
// Two-flop synchronizer, inversion and rising-edge detection.
module gpio_in_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] pol,
  output logic [W-1:0] din,
  output logic [W-1:0] rise
);

  logic [W-1:0] meta_q, sync_q, prev_q;

  always_comb begin
    din  = sync_q ^ pol;
    rise = din & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
      prev_q <= din;
    end
  end

endmodule

// File: rtl/gpio_blink_div.sv
// Free-running divider giving one shared blink phase.
module gpio_blink_div #(
  parameter int HALF = 16
) (
  input  logic clk,
  input  logic rst_ni,
  output logic phase
);

  localparam int CW = $clog2(HALF + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == LAST);
    cnt_d   = wrap ? '0 : cnt_q + 1'b1;
    phase_d = wrap ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/gpio_irq_merge.sv
// Per-line cause and per-group summary.
module gpio_irq_merge #(
  parameter int W     = 32,
  parameter int GROUP = 8
) (
  input  logic [W-1:0]         din,
  input  logic [W-1:0]         ecause,
  input  logic [W-1:0]         lmask,
  input  logic [W-1:0]         emask,
  output logic [W/GROUP-1:0]   irq
);

  localparam int NG = W / GROUP;

  logic [W-1:0] cause;

  always_comb cause = (din & lmask) | (ecause & emask);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign irq[g] = |cause[g*GROUP +: GROUP];
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank #(
  parameter int NUM_LINES  = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_HALF = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [gpio_bank_pkg::ADDR_W-1:0]  bus_addr,
  input  logic                              bus_we,
  input  logic [NUM_LINES-1:0]              bus_wdata,
  output logic [NUM_LINES-1:0]              bus_rdata,
  input  logic [NUM_LINES-1:0]              pad_in,
  output logic [NUM_LINES-1:0]              pad_out,
  output logic [NUM_LINES-1:0]              pad_oe,
  output logic [NUM_LINES/GROUP-1:0]        irq_grp
);
  import gpio_bank_pkg::*;

  localparam int W  = NUM_LINES;
  localparam int NG = NUM_LINES / GROUP;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  logic [W-1:0] dir_q, out_q, blink_q, pol_q, ecause_q, emask_q, lmask_q;
  logic [W-1:0] dir_d, out_d, blink_d, pol_d, ecause_d, emask_d, lmask_d;
  logic [W-1:0] din, rise;
  logic         phase;

  gpio_in_stage #(.W(W)) u_in (
    .clk    (clk),
    .rst_ni (rst_ni),
    .pad_in (pad_in),
    .pol    (pol_q),
    .din    (din),
    .rise   (rise)
  );

  gpio_blink_div #(.HALF(BLINK_HALF)) u_blink (
    .clk    (clk),
    .rst_ni (rst_ni),
    .phase  (phase)
  );

  gpio_irq_merge #(.W(W), .GROUP(GROUP)) u_irq (
    .din    (din),
    .ecause (ecause_q),
    .lmask  (lmask_q),
    .emask  (emask_q),
    .irq    (irq_grp)
  );

  // Register write decode (next state)
  always_comb begin
    dir_d    = dir_q;
    out_d    = out_q;
    blink_d  = blink_q;
    pol_d    = pol_q;
    emask_d  = emask_q;
    lmask_d  = lmask_q;
    ecause_d = ecause_q;
    if (bus_we) begin
      case (bus_addr)
        REG_DIR:    dir_d    = bus_wdata;
        REG_OUT:    out_d    = bus_wdata;
        REG_BLINK:  blink_d  = bus_wdata;
        REG_POL:    pol_d    = bus_wdata;
        REG_ECAUSE: ecause_d = ecause_q & bus_wdata;
        REG_EMASK:  emask_d  = bus_wdata;
        REG_LMASK:  lmask_d  = bus_wdata;
        default:    ;
      endcase
    end
    // a fresh edge outranks a clearing write
    ecause_d = ecause_d | rise;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q    <= '1;
      out_q    <= '0;
      blink_q  <= '0;
      pol_q    <= '0;
      ecause_q <= '0;
      emask_q  <= '0;
      lmask_q  <= '0;
    end else begin
      dir_q    <= dir_d;
      out_q    <= out_d;
      blink_q  <= blink_d;
      pol_q    <= pol_d;
      ecause_q <= ecause_d;
      emask_q  <= emask_d;
      lmask_q  <= lmask_d;
    end
  end

  // Read mux
  always_comb begin
    case (bus_addr)
      REG_DIR:    bus_rdata = dir_q;
      REG_OUT:    bus_rdata = out_q;
      REG_BLINK:  bus_rdata = blink_q;
      REG_POL:    bus_rdata = pol_q;
      REG_DIN:    bus_rdata = din;
      REG_ECAUSE: bus_rdata = ecause_q;
      REG_EMASK:  bus_rdata = emask_q;
      REG_LMASK:  bus_rdata = lmask_q;
      default:    bus_rdata = '0;
    endcase
  end

  // Pad drive
  always_comb begin
    pad_oe  = ~dir_q;
    pad_out = (out_q & ~blink_q) | (blink_q & {W{phase}});
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int W  = 32,
  parameter int NG = 4
) (
  input logic                              clk,
  input logic                              rst_ni,
  input logic [gpio_bank_pkg::ADDR_W-1:0]  bus_addr,
  input logic                              bus_we,
  input logic [W-1:0]                      bus_wdata,
  input logic [W-1:0]                      pad_oe,
  input logic [NG-1:0]                     irq_grp,
  input logic [W-1:0]                      ecause,
  input logic [W-1:0]                      rise,
  input logic [W-1:0]                      lmask,
  input logic [W-1:0]                      emask
);
  import gpio_bank_pkg::*;

  logic wr_dir, wr_ec;
  always_comb begin
    wr_dir = bus_we && (bus_addr == REG_DIR);
    wr_ec  = bus_we && (bus_addr == REG_ECAUSE);
  end

  assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_dir |=> (pad_oe == ~$past(bus_wdata)));

  assert_edge_set_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (|rise) |=> ((ecause & $past(rise)) == $past(rise)));

  assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_ec |=> ((ecause & $past(ecause)) == $past(ecause)));

  assert_zero_clears_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_ec |=> ((ecause & ~($past(ecause) & $past(bus_wdata)) & ~$past(rise)) == '0));

  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_ec && (|rise)) |=> ((ecause & $past(rise)) == $past(rise)));

  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    ((lmask == '0) && (emask == '0)) |-> (irq_grp == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.W(NUM_LINES), .NG(NUM_LINES/GROUP)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .irq_grp   (irq_grp),
  .ecause    (ecause_q),
  .rise      (rise),
  .lmask     (lmask_q),
  .emask     (emask_q)
);

// File: tb/tb_gpio_bank.sv
`timescale 1ns/1ps
module tb_gpio_bank;
  localparam int W    = 32;
  localparam int HALF = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [3:0]    bus_addr;
  logic          bus_we;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;
  logic [3:0]    irq_grp;

  always #5 clk = ~clk;

  gpio_bank #(.NUM_LINES(W), .GROUP(8), .BLINK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_grp(irq_grp)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 irq, 2 pad_out, 3 pad_oe
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic tally(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expectations and compares against the ports
  initial begin
    item_t it;
    logic [31:0] act;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = {28'd0, irq_grp};
        2:       act = pad_out;
        default: act = pad_oe;
      endcase
      tally(act === it.exp, it.req, act, it.exp);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic exp_reg(logic [3:0] a, logic [31:0] e, string req);
    bus_addr = a;
    #0.2;
    q.push_back('{0, e, req});
    wait (q.size() == 0);
  endtask

  task automatic exp_pin(int kind, logic [31:0] e, string req);
    #0.2;
    q.push_back('{kind, e, req});
    wait (q.size() == 0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int toggles;
    logic prev;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pad_in = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1 reset state
    exp_reg(4'd0, 32'hFFFF_FFFF, "R1 direction");
    exp_reg(4'd1, 32'h0, "R1 output level");
    exp_reg(4'd2, 32'h0, "R1 blink");
    exp_reg(4'd5, 32'h0, "R1 edge cause");
    exp_reg(4'd7, 32'h0, "R1 level mask");
    exp_pin(3, 32'h0, "R1 pad_oe");
    exp_pin(1, 32'h0, "R1 irq");
    exp_reg(4'd9, 32'h0, "R11 unused address");

    // R2 direction and output level
    wr(4'd0, 32'hFFFF_0000);
    wr(4'd1, 32'h0000_A5C3);
    exp_pin(3, 32'h0000_FFFF, "R2 pad_oe");
    exp_pin(2, 32'h0000_A5C3, "R2 pad_out");
    exp_reg(4'd1, 32'h0000_A5C3, "R11 output readback");
    wr(4'd8, 32'hDEAD_BEEF);
    exp_reg(4'd8, 32'h0, "R11 write to unused ignored");

    // R3 synchronizer latency
    pad_in = 32'h1234_5678;
    step(1);
    exp_reg(4'd4, 32'h0, "R3 data-in after one edge");
    step(1);
    exp_reg(4'd4, 32'h1234_5678, "R3 data-in after two edges");
    step(1);
    exp_reg(4'd5, 32'h1234_5678, "R4 edge cause set");

    // R10 inversion write creates edges
    wr(4'd3, 32'h0F0F_0F0F);
    exp_reg(4'd4, 32'h1D3B_5977, "R3 inverted data-in");
    step(1);
    exp_reg(4'd5, 32'h1F3F_5F7F, "R10 edge from inversion");

    // R4 sticky after input falls
    wr(4'd3, 32'h0);
    pad_in = 32'h0;
    step(4);
    exp_reg(4'd5, 32'h1F3F_5F7F, "R4 sticky cause");

    // R5 write-zero-to-clear
    wr(4'd5, 32'hFFFF_0000);
    exp_reg(4'd5, 32'h1F3F_0000, "R5 partial clear");
    wr(4'd5, 32'h0);
    exp_reg(4'd5, 32'h0, "R5 full clear");

    // R7 / R8 masks and grouping
    pad_in = 32'h0000_0100;
    step(2);
    exp_pin(1, 32'h0, "R7 masks off");
    step(1);
    wr(4'd7, 32'h0000_0100);
    exp_pin(1, 32'h2, "R8 level on group 1");
    wr(4'd7, 32'h0);
    exp_pin(1, 32'h0, "R7 edge cause without edge mask");
    wr(4'd6, 32'h0000_0100);
    exp_pin(1, 32'h2, "R7 edge mask");
    pad_in = 32'h0;
    step(2);
    exp_pin(1, 32'h2, "R7 edge cause outlives level");
    wr(4'd6, 32'h0);
    wr(4'd5, 32'h0);
    exp_pin(1, 32'h0, "R7 all quiet");
    pad_in = 32'h8000_0001;
    step(2);
    wr(4'd7, 32'h8000_0001);
    exp_pin(1, 32'h9, "R8 groups 0 and 3");
    wr(4'd7, 32'h0);
    pad_in = 32'h0;
    step(3);
    wr(4'd5, 32'h0);
    exp_reg(4'd5, 32'h0, "R5 cleanup");

    // R6 edge meets clearing write
    pad_in = 32'h0000_0004;
    step(2);
    wr(4'd5, 32'h0);
    exp_reg(4'd5, 32'h0000_0004, "R6 edge wins over clear");
    pad_in = 32'h0;
    step(3);
    wr(4'd5, 32'h0);

    // R9 blink
    wr(4'd2, 32'h0000_0003);
    exp_pin(2, 32'h0000_A5C0, "R9 other lines" );
    toggles = 0;
    for (int i = 0; i < 4*HALF; i++) begin
      prev = pad_out[0];
      step(1);
      #0.2;
      if (pad_out[0] !== prev) toggles++;
      tally(pad_out[0] === pad_out[1], "R9 shared phase",
            {31'd0, pad_out[1]}, {31'd0, pad_out[0]});
    end
    tally(toggles == 4, "R9 toggle count", toggles, 4);
    tally((pad_out & 32'h0000_FFFC) === 32'h0000_A5C0, "R9 non-blink lines",
          pad_out & 32'h0000_FFFC, 32'h0000_A5C0);
    wr(4'd2, 32'h0);
    exp_pin(2, 32'h0000_A5C3, "R9 blink off");

    wait (q.size() == 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule